// File: doc/BRIEF.md
# Horizontal Video Line Scaler

The block resamples one video line of luma pixels at a time in the horizontal direction. Pixels pass through two resampling stages in series. The first stage can only shrink the line and the second can only stretch it. Each stage keeps a fixed-point position with 10 fractional bits. For every output pixel the stage adds its step to that position and blends the two input pixels on either side of it. After the second stage a luma offset is added to every pixel, and the sum saturates at full scale. Every pixel path uses a valid/ready handshake, and an end-of-line marker beat closes each output line.

Software writes the settings into staging registers: the offset, the line length and the two step values. These settings do nothing until an update is requested through the control register. The update is then held until the next line start that arrives while no line is in flight. At that line start all settings move into the working set together, so no line is ever scaled with a mix of old and new values. A status output stays low while an update is waiting. Only the linear profile is implemented.

Top module: `hscl_top`

## Requirements
- R1: After reset, upd_o is 1, in_ready_o and out_valid_o are 0, and the working set is offset 57, line length 1080, shrink step 1024 and stretch step 1024.
- R2: Writes to address 1 (offset, bits [6:0]), address 2 (line length, bits [11:0]), address 3 (shrink step, bits [11:0]) and address 4 (stretch step, bits [11:0]) do not change the processing of any line until an update has been committed.
- R3: A write to address 0 with bit 2 = 0 requests an update. upd_o reads 0 from the cycle after that write. The update commits at the first clock edge where line_start_i is 1 and no line is in flight, and upd_o reads 1 from the cycle after. While a line is in flight, line_start_i has no effect and the working set does not change.
- R4: A write to address 0 with bit 2 = 1 requests no update. upd_o stays 1 and the working set does not change.
- R5: After an accepted line start, exactly the working line length of input pixels is accepted. After that, in_ready_o stays 0 until the next line start. Each line ends with one output beat that has out_eol_o = 1. When no line is in flight, in_ready_o and out_valid_o are 0.
- R6: With shrink step S, the first stage emits one pixel for each k >= 0 with k*S <= (N-1)*1024, where N is the number of pixels in the line. Output k is taken at input position k*S/1024.
- R7: With stretch step E, the second stage resamples the first stage's output in the same way, at positions k*E/1024.
- R8: At position x, with i = x>>10 and w = (x>>6) mod 16, a stage outputs (p[i]*(16-w) + p[i+1]*w)>>4. When i is the last pixel, p[i+1] is replaced by p[i].
- R9: Each output pixel equals the second stage's result plus the working offset, saturated at 255.
- R10: On commit, a shrink step below 1024 becomes 1024, a stretch step below 256 becomes 256, a stretch step above 1024 becomes 1024, and a line length of 0 becomes 1.
- R11: While out_valid_o is 1 and out_ready_i is 0, the output beat (pixel and end-of-line flag) is held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 12 | Register write data |
| upd_o | output | 1 | Update status: 0 while an update is waiting, 1 once it is loaded |
| line_start_i | input | 1 | Line start request |
| in_valid_i | input | 1 | Input pixel valid |
| in_pix_i | input | 8 | Input luma pixel |
| in_ready_o | output | 1 | Input pixel accepted |
| out_valid_o | output | 1 | Output beat valid |
| out_pix_o | output | 8 | Output luma pixel |
| out_eol_o | output | 1 | Output beat is the end-of-line marker; it carries no pixel |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The hardest case to reach is an update request that lands in the middle of a line. A line start pulse then arrives while that line is still being processed. The commit must wait for the next idle line start, and the line in flight must keep its old length and steps. The bench gets there by issuing the control write and an extra line start a few cycles into a line, while it throttles both the input valid and the output ready with periodic patterns. It then checks that upd_o stays low after the line ends and rises only after the following line start. The clamping rules and the last-pixel rule are reached with out-of-range step values and with one-pixel lines.

// File: rtl/hscl_pkg.sv
package hscl_pkg;
  localparam int unsigned CFG_W  = 12;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned OFFS_W = 7;
  localparam int unsigned FRAC_W = 10;
  localparam int unsigned WT_W   = 4;
  localparam int unsigned UPD_BIT = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OFFS = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LEN  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SHR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STR  = 3'd4;

  localparam logic [CFG_W-1:0] UNITY   = CFG_W'(1 << FRAC_W);
  localparam logic [CFG_W-1:0] STR_MIN = CFG_W'((1 << FRAC_W) >> 2);

  typedef struct packed {
    logic [OFFS_W-1:0] offs;
    logic [CFG_W-1:0]  len;
    logic [CFG_W-1:0]  shr;
    logic [CFG_W-1:0]  str;
  } cfg_t;

  localparam cfg_t CFG_RST = '{offs: OFFS_W'(57), len: CFG_W'(1080), shr: UNITY, str: UNITY};

  function automatic cfg_t clamp_cfg(input cfg_t s);
    cfg_t r;
    r = s;
    if (s.shr < UNITY) r.shr = UNITY;
    if (s.str < STR_MIN) r.str = STR_MIN;
    else if (s.str > UNITY) r.str = UNITY;
    if (s.len == '0) r.len = CFG_W'(1);
    return r;
  endfunction
endpackage

// File: rtl/hscl_regs.sv
module hscl_regs
  import hscl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              start_i,
  output logic              upd_o,
  output cfg_t              work_o
);
  cfg_t shadow_q, work_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CFG_RST;
      work_q   <= CFG_RST;
      pend_q   <= 1'b0;
    end else begin
      if (start_i && pend_q) begin
        work_q <= clamp_cfg(shadow_q);
        pend_q <= 1'b0;
      end
      // a request in the commit cycle stays queued for the next boundary
      if (cfg_we_i) begin
        case (cfg_addr_i)
          ADR_CTRL: if (!cfg_wdata_i[UPD_BIT]) pend_q <= 1'b1;
          ADR_OFFS: shadow_q.offs <= cfg_wdata_i[OFFS_W-1:0];
          ADR_LEN:  shadow_q.len  <= cfg_wdata_i;
          ADR_SHR:  shadow_q.shr  <= cfg_wdata_i;
          ADR_STR:  shadow_q.str  <= cfg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign upd_o  = !pend_q;
  assign work_o = work_q;
endmodule

// File: rtl/hscl_stage.sv
module hscl_stage #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned INC_W  = 12,
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned WT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             in_valid_i,
  input  logic             in_end_i,
  input  logic [PIX_W-1:0] in_pix_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             out_end_o,
  output logic [PIX_W-1:0] out_pix_o,
  input  logic             out_ready_i
);
  localparam int unsigned ACC_W = INC_W + 1;
  localparam int unsigned MIX_W = PIX_W + WT_W + 1;
  localparam logic [ACC_W-1:0] ONE_A = ACC_W'(1 << FRAC_W);
  localparam logic [WT_W:0]    WT_ONE = (WT_W+1)'(1 << WT_W);

  logic [PIX_W-1:0] a_q, b_q;
  logic             a_vld_q, b_vld_q, eol_q;
  logic [ACC_W-1:0] acc_q;

  logic [FRAC_W-1:0] frac;
  logic [WT_W-1:0]   wt;
  logic              skip_nz, a_last, shift, emit, done;
  logic [PIX_W-1:0]  b_sel;
  logic [MIX_W-1:0]  mix;

  assign frac    = acc_q[FRAC_W-1:0];
  assign skip_nz = |acc_q[ACC_W-1:FRAC_W];
  assign wt      = frac[FRAC_W-1 -: WT_W];
  assign a_last  = a_vld_q && !b_vld_q && eol_q;
  // advance the sample pair: initial fill or integer part still pending
  assign shift   = b_vld_q && (!a_vld_q || skip_nz);
  assign emit    = a_vld_q && !skip_nz && (b_vld_q || (a_last && frac == '0));
  assign done    = (a_last && (skip_nz || frac != '0)) || (eol_q && !a_vld_q && !b_vld_q);

  assign in_ready_o  = !eol_q && (!b_vld_q || shift);
  assign out_valid_o = emit || done;
  assign out_end_o   = done;

  assign b_sel = b_vld_q ? b_q : a_q;
  assign mix   = MIX_W'(a_q) * MIX_W'(WT_ONE - (WT_W+1)'(wt)) + MIX_W'(b_sel) * MIX_W'(wt);
  assign out_pix_o = PIX_W'(mix >> WT_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      a_vld_q <= 1'b0;
      b_vld_q <= 1'b0;
      eol_q   <= 1'b0;
      acc_q   <= '0;
    end else if (done && out_ready_i) begin
      a_vld_q <= 1'b0;
      b_vld_q <= 1'b0;
      eol_q   <= 1'b0;
      acc_q   <= '0;
    end else begin
      if (emit && out_ready_i) acc_q <= ACC_W'(frac) + ACC_W'(inc_i);
      if (shift) begin
        a_q     <= b_q;
        a_vld_q <= 1'b1;
        b_vld_q <= 1'b0;
        if (a_vld_q) acc_q <= acc_q - ONE_A;
      end
      if (in_valid_i && in_ready_o) begin
        if (in_end_i) eol_q <= 1'b1;
        else begin
          b_q     <= in_pix_i;
          b_vld_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hscl_top.sv
module hscl_top
  import hscl_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              upd_o,
  input  logic              line_start_i,
  input  logic              in_valid_i,
  input  logic [PIX_W-1:0]  in_pix_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [PIX_W-1:0]  out_pix_o,
  output logic              out_eol_o,
  input  logic              out_ready_i
);
  localparam int unsigned NSTG  = 2;
  localparam int unsigned CNT_W = CFG_W + 1;

  cfg_t work;
  logic busy_q, start;
  logic [CNT_W-1:0] cnt_q, len_c;

  logic             s_vld [NSTG+1];
  logic             s_end [NSTG+1];
  logic             s_rdy [NSTG+1];
  logic [PIX_W-1:0] s_pix [NSTG+1];
  logic [CFG_W-1:0] s_inc [NSTG];

  assign start = line_start_i && !busy_q;
  assign len_c = CNT_W'(work.len);

  hscl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .start_i     (start),
    .upd_o       (upd_o),
    .work_o      (work)
  );

  // pixels until the count is reached, then one end token
  assign s_vld[0] = busy_q && ((cnt_q < len_c) ? in_valid_i : (cnt_q == len_c));
  assign s_end[0] = (cnt_q == len_c);
  assign s_pix[0] = in_pix_i;
  assign in_ready_o = busy_q && (cnt_q < len_c) && s_rdy[0];

  assign s_inc[0] = work.shr;
  assign s_inc[1] = work.str;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    hscl_stage #(
      .PIX_W  (PIX_W),
      .INC_W  (CFG_W),
      .FRAC_W (FRAC_W),
      .WT_W   (WT_W)
    ) u_stage (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .inc_i       (s_inc[g]),
      .in_valid_i  (s_vld[g]),
      .in_end_i    (s_end[g]),
      .in_pix_i    (s_pix[g]),
      .in_ready_o  (s_rdy[g]),
      .out_valid_o (s_vld[g+1]),
      .out_end_o   (s_end[g+1]),
      .out_pix_o   (s_pix[g+1]),
      .out_ready_i (s_rdy[g+1])
    );
  end

  assign s_rdy[NSTG] = out_ready_i;

  logic [PIX_W:0] sum;
  assign sum         = {1'b0, s_pix[NSTG]} + (PIX_W+1)'(work.offs);
  assign out_pix_o   = sum[PIX_W] ? '1 : sum[PIX_W-1:0];
  assign out_valid_o = s_vld[NSTG];
  assign out_eol_o   = s_end[NSTG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        if (s_vld[0] && s_rdy[0]) cnt_q <= cnt_q + 1'b1;
        if (out_valid_o && out_eol_o && out_ready_i) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hscl_chk.sv
module hscl_chk
  import hscl_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             line_start_i,
  input logic             upd_i,
  input logic             in_ready_i,
  input logic             out_valid_i,
  input logic             out_ready_i,
  input logic [PIX_W-1:0] out_pix_i,
  input logic             out_eol_i,
  input cfg_t             work_i
);
  AST_UPD_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_i) |-> $past(line_start_i && !busy_i)); // R3

  AST_WORK_FROZEN_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(work_i)); // R3

  AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!in_ready_i && !out_valid_i)); // R5

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(out_pix_i) && $stable(out_eol_i))); // R11

  AST_WORK_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (work_i.shr >= UNITY) && (work_i.str >= STR_MIN) && (work_i.str <= UNITY) && (work_i.len != '0)); // R10
endmodule

bind hscl_top hscl_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_q),
  .line_start_i (line_start_i),
  .upd_i        (upd_o),
  .in_ready_i   (in_ready_o),
  .out_valid_i  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_pix_i    (out_pix_o),
  .out_eol_i    (out_eol_o),
  .work_i       (work)
);

// File: tb/hscl_top_tb_top.sv
module hscl_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        upd;
  logic        line_start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_pix;
  logic        out_eol;
  logic        out_ready = 1'b0;

  hscl_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .upd_o(upd),
    .line_start_i(line_start),
    .in_valid_i(in_valid), .in_pix_i(in_pix), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_pix_o(out_pix), .out_eol_o(out_eol), .out_ready_i(out_ready)
  );

  int n_chk = 0, n_fail = 0, gcyc = 0;
  int in_buf [2048];
  int s1_buf [4096];
  int exp_buf [8192];
  int exp_n = 0;
  int sh_len = 1080, sh_shr = 1024, sh_str = 1024, sh_off = 57;
  int w_len = 1080, w_shr = 1024, w_str = 1024, w_off = 57;
  bit pend = 1'b0;

  // len, shrink step, stretch step, offset, seed, tag
  localparam int NV = 12;
  localparam int VEC [NV][6] = '{
    '{16, 1024, 1024,   0,  1, 6},
    '{20, 2048, 1024,   0,  2, 6},
    '{17, 1536, 1024,  10,  3, 8},
    '{12, 1024,  512,   0,  4, 7},
    '{10, 1024,  256,   5,  5, 7},
    '{25, 3000,  700,  20,  6, 8},
    '{ 9, 4095, 1024,   0,  7, 6},
    '{ 1, 2048,  256,   0,  8, 8},
    '{30, 1300,  300, 127,  9, 9},
    '{ 8,  100, 2000,   0, 10, 10},
    '{ 8, 1024,   10,   0, 11, 10},
    '{ 0, 1024,  512,   3, 12, 10}
  };

  function automatic string rtag(input int t);
    case (t)
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", gcyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic write_cfg(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 12'(d);
    case (a)
      1: sh_off = d & 127;
      2: sh_len = d & 4095;
      3: sh_shr = d & 4095;
      4: sh_str = d & 4095;
      default: if (((d >> 2) & 1) == 0) pend = 1'b1;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R10 clamp rules applied when the bench's own working copy is loaded
  task automatic apply_commit();
    if (pend) begin
      w_off = sh_off;
      w_len = (sh_len == 0) ? 1 : sh_len;
      w_shr = (sh_shr < 1024) ? 1024 : sh_shr;
      w_str = (sh_str < 256) ? 256 : ((sh_str > 1024) ? 1024 : sh_str);
      pend = 1'b0;
    end
  endtask

  // R6, R7, R8, R9 expected line
  task automatic build_exp(input int seed);
    int n, m1;
    n = w_len;
    m1 = 0;
    for (int i = 0; i < n; i++) in_buf[i] = (seed * 71 + i * 29 + ((i * i) % 13) * 7) & 255;
    for (int k = 0; k * w_shr <= (n - 1) * 1024; k++) begin
      int x, ix, wt, b;
      x = k * w_shr; ix = x >> 10; wt = (x >> 6) & 15;
      b = (ix + 1 < n) ? in_buf[ix + 1] : in_buf[ix];
      s1_buf[k] = (in_buf[ix] * (16 - wt) + b * wt) >> 4;
      m1 = k + 1;
    end
    exp_n = 0;
    for (int k = 0; k * w_str <= (m1 - 1) * 1024; k++) begin
      int x, ix, wt, b, v;
      x = k * w_str; ix = x >> 10; wt = (x >> 6) & 15;
      b = (ix + 1 < m1) ? s1_buf[ix + 1] : s1_buf[ix];
      v = ((s1_buf[ix] * (16 - wt) + b * wt) >> 4) + w_off;
      exp_buf[k] = (v > 255) ? 255 : v;
      exp_n = k + 1;
    end
  endtask

  task automatic run_line(input string tag, input bit chk_upd, input bit mid);
    int fed, oi, cyc;
    bit fin;
    fed = 0; oi = 0; cyc = 0; fin = 1'b0;
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      line_start = (cyc == 0) || (mid && cyc == 6);
      cfg_we = mid && cyc == 4;
      cfg_addr = 3'd0; cfg_wdata = 12'd0;
      if (mid && cyc == 4) pend = 1'b1;
      in_valid = (cyc % 7) != 2;
      in_pix = 8'(in_buf[fed]);
      out_ready = (cyc % 5) != 3;
      if (chk_upd && cyc == 1) check(upd == 1'b1, "R3", "upd after boundary", int'(upd), 1);
      if (in_valid && in_ready) fed++;
      if (out_valid && out_ready) begin
        if (out_eol) fin = 1'b1;
        else begin
          if (oi < exp_n) check(int'(out_pix) == exp_buf[oi], tag, $sformatf("pixel %0d", oi), int'(out_pix), exp_buf[oi]);
          else check(1'b0, tag, "extra pixel", oi, exp_n);
          oi++;
        end
      end
      cyc++;
    end
    @(negedge clk);
    line_start = 1'b0; cfg_we = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    check(fin, "R5", "end marker seen", int'(fin), 1);
    check(oi == exp_n, tag, "output count", oi, exp_n);
    check(fed == w_len, "R5", "pixels accepted", fed, w_len);
    check(!in_ready && !out_valid, "R5", "idle after line", int'(in_ready) + 2 * int'(out_valid), 0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(upd == 1'b1, "R1", "upd in reset", int'(upd), 1);
    check(!in_ready && !out_valid, "R1", "idle in reset", int'(in_ready) + 2 * int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(upd == 1'b1, "R1", "upd after reset", int'(upd), 1);

    // R2 staging writes without commit: reset working set applies
    write_cfg(1, 0);
    write_cfg(2, 8);
    write_cfg(3, 2048);
    check(upd == 1'b1, "R2", "no update requested", int'(upd), 1);
    build_exp(99);
    run_line("R2", 1'b0, 1'b0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      write_cfg(1, VEC[v][3]);
      write_cfg(2, VEC[v][0]);
      write_cfg(3, VEC[v][1]);
      write_cfg(4, VEC[v][2]);
      write_cfg(0, 0);
      check(upd == 1'b0, "R3", "upd after request", int'(upd), 0);
      apply_commit();
      build_exp(VEC[v][4]);
      run_line(rtag(VEC[v][5]), 1'b1, 1'b0);
    end

    // R4 control write with update bit set
    write_cfg(2, 5);
    write_cfg(0, 4);
    check(upd == 1'b1, "R4", "upd with bit2 set", int'(upd), 1);
    apply_commit();
    build_exp(40);
    run_line("R4", 1'b0, 1'b0);

    // R3 request and extra line start inside a busy line
    write_cfg(2, 20);
    write_cfg(3, 1024);
    write_cfg(4, 512);
    write_cfg(1, 0);
    build_exp(41);
    run_line("R3", 1'b0, 1'b1);
    check(upd == 1'b0, "R3", "commit held while busy", int'(upd), 0);
    repeat (3) @(negedge clk);
    check(upd == 1'b0, "R3", "commit held while idle", int'(upd), 0);
    apply_commit();
    build_exp(42);
    run_line("R3", 1'b1, 1'b0);

    summary();
    $finish;
  end
endmodule